// File: doc/BRIEF.md
# Mask-Based Multi-Source Interrupt Controller

This block collects level interrupt requests from devices and turns them into one interrupt request and a 4-bit priority index for a processor core. Each device line sets a sticky bit in a per-processor pending register. That pending bit reaches the core only when three masks allow it: a per-processor mask, a master mask with one bit for each system source, and a master mask-all bit that silences everything.

Software reaches the block through a 32-bit word-addressed port. A bank select bit picks the per-processor bank or the master bank, and a 3-bit word offset picks the register inside the bank. Every mask changes only through two write-only registers per bank. Writing a one to the clear register unmasks that bit, which enables the source. Writing a one to the set register masks that bit, which disables the source. Zero bits have no effect in either register, so several agents can change the masks without a read-modify-write sequence. The master bank also holds a small routing-target register that software can read and write. The value of that register is driven straight out to the routing fabric.

Top module: `ic_mask_ctrl`

## Requirements
- R1: After reset, every pending bit is 0. Both the per-processor mask and the master mask read as all ones, with master bit 31 set. The target register is 0, irq_level is 0 and irq_req is 0.
- R2: While dev_irq[n] is high at a clock edge, pending bit n is set. The bit stays set after the input falls. Per-processor offset 0 reads back the pending register.
- R3: A write to per-processor offset 0 loads the pending register with the write data. Any dev_irq line that is high in the same cycle is ORed into the loaded value.
- R4: A write to a clear register clears each mask bit that is written as 1. The per-processor clear register is at offset 1 and the master clear register is at offset 2. Mask bits written as 0 keep their value.
- R5: A write to a set register sets each mask bit that is written as 1. The per-processor set register is at offset 2 and the master set register is at offset 3. Mask bits written as 0 keep their value.
- R6: While master mask bit 31 is 1, irq_level is 0 and irq_req is 0, whatever is pending.
- R7: Each hard level maps to one master source bit, as level->bit: 1->13, 2->7, 3->8, 4->18, 5->9, 6->16, 7->10, 8->20, 9->11, 10->19, 11->22, 12->15, 13->17, 14->12, 15->30. Level 0 has no source. Master offset 0 reads the mapped bit of every pending hard level.
- R8: Hard level n (1 to 15) qualifies when all three of these hold: pending bit n is 1, per-processor mask bit n is 0, and master mask bit map(n) is 0.
- R9: Soft level n (1 to 15) qualifies when pending bit 16+n is 1 and per-processor mask bit 16+n is 0. The master source bits play no part for soft levels.
- R10: irq_level is the highest level n whose hard or soft condition qualifies. Level 0 never produces an index. irq_req is 1 exactly when irq_level is nonzero.
- R11: Master offset 4 is the target register. It is read/write in its low TGT_W bits, its upper bits read 0, and it drives irq_target.
- R12: bus_rdata is updated in the cycle after a read request. A read of a write-only offset or an unmapped offset returns 0. A write to master offset 1 or to an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | 0 = per-processor bank, 1 = master bank |
| bus_addr | input | 3 | Word offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| dev_irq | input | 16 | Device interrupt lines, one for each level |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 4 | Highest qualifying level |
| irq_target | output | TGT_W | Routing target register |

## Verification
The hardest situation to reach is a hard level that actually fires. Reset leaves both masks and the mask-all bit set, and three independent mask bits plus a pending bit must line up before any index appears. The stimulus therefore biases its mask writes: clear writes carry dense random values, set writes are the AND of several random words so they stay sparse, and device pulses are thin. This keeps the mask-all bit and the mapped source bits open often enough for hard and soft levels to compete. Directed steps first walk one level through each gate in turn, then test the mask-all bit, pending writes made in the same cycle as an arrival, and writes to read-only offsets.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int DW     = 32;
  localparam int LEVELS = 16;
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int OFF_W  = 3;
  localparam int SOFT_BASE = 16;
  localparam int MASKALL_BIT = 31;

  // per-processor bank offsets
  localparam logic [OFF_W-1:0] CPU_PEND = 3'd0;
  localparam logic [OFF_W-1:0] CPU_CLR  = 3'd1;
  localparam logic [OFF_W-1:0] CPU_SET  = 3'd2;
  // master bank offsets
  localparam logic [OFF_W-1:0] MST_PEND = 3'd0;
  localparam logic [OFF_W-1:0] MST_MASK = 3'd1;
  localparam logic [OFF_W-1:0] MST_CLR  = 3'd2;
  localparam logic [OFF_W-1:0] MST_SET  = 3'd3;
  localparam logic [OFF_W-1:0] MST_TGT  = 3'd4;

  typedef struct packed {
    logic       hit;
    logic [4:0] pos;
  } src_map_t;

  // Fixed wiring of hard levels onto master source bits.
  function automatic src_map_t level_src(input int unsigned lvl);
    src_map_t m;
    m.hit = 1'b1;
    case (lvl)
      1:  m.pos = 5'd13;
      2:  m.pos = 5'd7;
      3:  m.pos = 5'd8;
      4:  m.pos = 5'd18;
      5:  m.pos = 5'd9;
      6:  m.pos = 5'd16;
      7:  m.pos = 5'd10;
      8:  m.pos = 5'd20;
      9:  m.pos = 5'd11;
      10: m.pos = 5'd19;
      11: m.pos = 5'd22;
      12: m.pos = 5'd15;
      13: m.pos = 5'd17;
      14: m.pos = 5'd12;
      15: m.pos = 5'd30;
      default: begin
        m.hit = 1'b0;
        m.pos = 5'd0;
      end
    endcase
    return m;
  endfunction

  // Highest set bit above bit 0, or zero.
  function automatic logic [LVL_W-1:0] top_level(input logic [LEVELS-1:0] q);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < LEVELS; i++) begin
      if (q[i]) r = LVL_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/ic_bus_decode.sv
module ic_bus_decode
  import ic_pkg::*;
(
  input  logic             valid,
  input  logic             write,
  input  logic             bank,
  input  logic [OFF_W-1:0] addr,
  output logic             cpu_pend_wr,
  output logic             cpu_clr_wr,
  output logic             cpu_set_wr,
  output logic             mst_clr_wr,
  output logic             mst_set_wr,
  output logic             mst_tgt_wr,
  output logic             rd_req
);
  logic wr_cpu, wr_mst;

  assign wr_cpu = valid && write && !bank;
  assign wr_mst = valid && write && bank;
  assign rd_req = valid && !write;

  assign cpu_pend_wr = wr_cpu && (addr == CPU_PEND);
  assign cpu_clr_wr  = wr_cpu && (addr == CPU_CLR);
  assign cpu_set_wr  = wr_cpu && (addr == CPU_SET);
  assign mst_clr_wr  = wr_mst && (addr == MST_CLR);
  assign mst_set_wr  = wr_mst && (addr == MST_SET);
  assign mst_tgt_wr  = wr_mst && (addr == MST_TGT);
endmodule

// File: rtl/ic_cpu_bank.sv
module ic_cpu_bank
  import ic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_wr,
  input  logic              clr_wr,
  input  logic              set_wr,
  input  logic [DW-1:0]     wdata,
  input  logic [LEVELS-1:0] dev_irq,
  output logic [DW-1:0]     pend,
  output logic [DW-1:0]     cmask
);
  logic [DW-1:0] arrivals;
  assign arrivals = {{(DW-LEVELS){1'b0}}, dev_irq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (pend_wr) begin
      pend <= wdata | arrivals;
    end else begin
      pend <= pend | arrivals;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmask <= '1;
    end else if (clr_wr) begin
      cmask <= cmask & ~wdata;
    end else if (set_wr) begin
      cmask <= cmask | wdata;
    end
  end

  assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend & $past(pend)) == $past(pend)));
  assert_arrival_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(arrivals)) == $past(arrivals)));
  assert_clr_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((cmask & $past(wdata)) == '0));
  assert_clr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((cmask & ~$past(wdata)) == ($past(cmask) & ~$past(wdata))));
  assert_set_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((cmask & $past(wdata)) == $past(wdata)));
  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_wr || set_wr) |=> $stable(cmask));
endmodule

// File: rtl/ic_master_bank.sv
module ic_master_bank
  import ic_pkg::*;
#(
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wr,
  input  logic             set_wr,
  input  logic             tgt_wr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    pend,
  output logic [DW-1:0]    mmask,
  output logic [DW-1:0]    mpend,
  output logic [TGT_W-1:0] tgt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmask <= '1;
    end else if (clr_wr) begin
      mmask <= mmask & ~wdata;
    end else if (set_wr) begin
      mmask <= mmask | wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt <= '0;
    end else if (tgt_wr) begin
      tgt <= wdata[TGT_W-1:0];
    end
  end

  // Master pending view: each pending hard level lights its source bit.
  always_comb begin
    mpend = '0;
    for (int n = 1; n < LEVELS; n++) begin
      src_map_t m;
      m = level_src(n);
      if (m.hit && pend[n]) mpend[m.pos] = 1'b1;
    end
  end

  assert_mclr_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((mmask & $past(wdata)) == '0));
  assert_mset_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((mmask & ~$past(wdata)) == ($past(mmask) & ~$past(wdata))));
  assert_mmask_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_wr || set_wr) |=> $stable(mmask));
  assert_tgt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr |=> $stable(tgt));
endmodule

// File: rtl/ic_qual_prio.sv
module ic_qual_prio
  import ic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    pend,
  input  logic [DW-1:0]    cmask,
  input  logic [DW-1:0]    mmask,
  output logic [LVL_W-1:0] level,
  output logic             req
);
  logic [LEVELS-1:0] hard_q, soft_q, qual;
  logic              mask_all;

  assign mask_all = mmask[MASKALL_BIT];

  always_comb begin
    hard_q = '0;
    soft_q = '0;
    for (int n = 1; n < LEVELS; n++) begin
      src_map_t m;
      m = level_src(n);
      hard_q[n] = pend[n] && !cmask[n] && m.hit && !mmask[m.pos];
      soft_q[n] = pend[SOFT_BASE+n] && !cmask[SOFT_BASE+n];
    end
  end

  assign qual  = hard_q | soft_q;
  assign level = mask_all ? '0 : top_level(qual);
  assign req   = (level != '0);

  assert_maskall_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |-> (level == '0));
  assert_level_qualifies_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> qual[level]);
  assert_level_is_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> ((qual >> level) == LEVELS'(1)));
  assert_open_not_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_all && (qual[LEVELS-1:1] != '0)) |-> req);
endmodule

// File: rtl/ic_mask_ctrl.sv
module ic_mask_ctrl
  import ic_pkg::*;
#(
  parameter int TGT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_bank,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [LEVELS-1:0] dev_irq,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level,
  output logic [TGT_W-1:0]  irq_target
);
  logic          cpu_pend_wr, cpu_clr_wr, cpu_set_wr;
  logic          mst_clr_wr, mst_set_wr, mst_tgt_wr, rd_req;
  logic [DW-1:0] pend, cmask, mmask, mpend, rd_mux;
  logic [TGT_W-1:0] tgt;

  ic_bus_decode u_dec (
    .valid(bus_valid), .write(bus_write), .bank(bus_bank), .addr(bus_addr),
    .cpu_pend_wr(cpu_pend_wr), .cpu_clr_wr(cpu_clr_wr), .cpu_set_wr(cpu_set_wr),
    .mst_clr_wr(mst_clr_wr), .mst_set_wr(mst_set_wr), .mst_tgt_wr(mst_tgt_wr),
    .rd_req(rd_req)
  );

  ic_cpu_bank u_cpu (
    .clk(clk), .rst_n(rst_n), .pend_wr(cpu_pend_wr), .clr_wr(cpu_clr_wr),
    .set_wr(cpu_set_wr), .wdata(bus_wdata), .dev_irq(dev_irq),
    .pend(pend), .cmask(cmask)
  );

  ic_master_bank #(.TGT_W(TGT_W)) u_mst (
    .clk(clk), .rst_n(rst_n), .clr_wr(mst_clr_wr), .set_wr(mst_set_wr),
    .tgt_wr(mst_tgt_wr), .wdata(bus_wdata), .pend(pend),
    .mmask(mmask), .mpend(mpend), .tgt(tgt)
  );

  ic_qual_prio u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .cmask(cmask), .mmask(mmask),
    .level(irq_level), .req(irq_req)
  );

  always_comb begin
    rd_mux = '0;
    if (!bus_bank) begin
      if (bus_addr == CPU_PEND) rd_mux = pend;
    end else begin
      case (bus_addr)
        MST_PEND: rd_mux = mpend;
        MST_MASK: rd_mux = mmask;
        MST_TGT:  rd_mux = {{(DW-TGT_W){1'b0}}, tgt};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  assign irq_target = tgt;

  assert_wo_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_bank && (bus_addr != CPU_PEND)) |=> (bus_rdata == '0));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));
  assert_tgt_readback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_bank && (bus_addr == MST_TGT)) |=> (bus_rdata[TGT_W-1:0] == irq_target));
endmodule

// File: tb/tb_ic_mask_ctrl.sv
module tb_ic_mask_ctrl;
  localparam int TGT_W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_bank = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] dev_irq = '0;
  logic        irq_req;
  logic [3:0]  irq_level;
  logic [TGT_W-1:0] irq_target;

  ic_mask_ctrl #(.TGT_W(TGT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_irq(dev_irq), .irq_req(irq_req),
    .irq_level(irq_level), .irq_target(irq_target)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_pend, m_cmask, m_mmask;
  logic [TGT_W-1:0] m_tgt;
  int src_of [16];

  function automatic logic [31:0] mst_view(input logic [31:0] p);
    logic [31:0] v = '0;
    for (int k = 1; k < 16; k++) if (p[k]) v[src_of[k]] = 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] want_level(input logic [31:0] p, input logic [31:0] cm,
                                            input logic [31:0] mm);
    if (mm[31]) return 4'd0;
    for (int k = 15; k >= 1; k--) begin
      if (p[k] && !cm[k] && !mm[src_of[k]]) return 4'(k);
      if (p[16+k] && !cm[16+k]) return 4'(k);
    end
    return 4'd0;
  endfunction

  function automatic logic [31:0] want_read(input logic bank, input logic [2:0] a);
    if (!bank) return (a == 3'd0) ? m_pend : 32'd0;
    case (a)
      3'd0: return mst_view(m_pend);
      3'd1: return m_mmask;
      3'd4: return {{(32-TGT_W){1'b0}}, m_tgt};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: inputs already driven; model updated, outputs checked at negedge.
  task automatic step(input string tag);
    logic [31:0] exp_rd;
    logic        was_rd;
    logic [3:0]  lv;
    was_rd = bus_valid && !bus_write;
    exp_rd = want_read(bus_bank, bus_addr);
    if (bus_valid && bus_write && !bus_bank) begin
      if (bus_addr == 3'd0) m_pend = bus_wdata;
      if (bus_addr == 3'd1) m_cmask = m_cmask & ~bus_wdata;
      if (bus_addr == 3'd2) m_cmask = m_cmask | bus_wdata;
    end
    if (bus_valid && bus_write && bus_bank) begin
      if (bus_addr == 3'd2) m_mmask = m_mmask & ~bus_wdata;
      if (bus_addr == 3'd3) m_mmask = m_mmask | bus_wdata;
      if (bus_addr == 3'd4) m_tgt = bus_wdata[TGT_W-1:0];
    end
    m_pend = m_pend | {16'd0, dev_irq};
    @(posedge clk);
    @(negedge clk);
    lv = want_level(m_pend, m_cmask, m_mmask);
    chk({tag, " R10 level"}, {28'd0, irq_level}, {28'd0, lv});
    chk({tag, " R10 req"}, {31'd0, irq_req}, {31'd0, (lv != 0)});
    chk({tag, " R11 target"}, {{(32-TGT_W){1'b0}}, irq_target}, {{(32-TGT_W){1'b0}}, m_tgt});
    if (was_rd) chk({tag, " R12 rdata"}, bus_rdata, exp_rd);
    bus_valid = 1'b0;
    bus_write = 1'b0;
    dev_irq = '0;
  endtask

  task automatic wr(input logic bank, input logic [2:0] a, input logic [31:0] d,
                    input string tag);
    bus_valid = 1'b1; bus_write = 1'b1; bus_bank = bank; bus_addr = a; bus_wdata = d;
    step(tag);
  endtask

  task automatic rd(input logic bank, input logic [2:0] a, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_bank = bank; bus_addr = a;
    step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    src_of[0] = 0;  src_of[1] = 13; src_of[2] = 7;  src_of[3] = 8;
    src_of[4] = 18; src_of[5] = 9;  src_of[6] = 16; src_of[7] = 10;
    src_of[8] = 20; src_of[9] = 11; src_of[10] = 19; src_of[11] = 22;
    src_of[12] = 15; src_of[13] = 17; src_of[14] = 12; src_of[15] = 30;
    m_pend = '0; m_cmask = '1; m_mmask = '1; m_tgt = '0;
    seed = $urandom(32'h1c0ffee);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level after reset", {28'd0, irq_level}, 32'd0);
    rd(1'b1, 3'd1, "R1 master mask reset");
    rd(1'b1, 3'd4, "R1 target reset");
    rd(1'b0, 3'd0, "R1 pending reset");

    dev_irq = 16'h0040; step("R2 pulse level 6");
    rd(1'b0, 3'd0, "R2 pending sticky");
    chk("R2 pend readback", bus_rdata, 32'h0000_0040);
    wr(1'b1, 3'd2, 32'h8001_0000, "R8 open master src");
    chk("R8 cpu mask still closed", {28'd0, irq_level}, 32'd0);
    wr(1'b0, 3'd1, 32'h0000_0040, "R8 open cpu bit 6");
    chk("R8 level 6 fires", {28'd0, irq_level}, 32'd6);
    rd(1'b1, 3'd0, "R7 master pending view");
    chk("R7 eth bit", bus_rdata, 32'h0001_0000);
    wr(1'b1, 3'd3, 32'h8000_0000, "R6 mask all");
    chk("R6 silenced", {28'd0, irq_level}, 32'd0);
    wr(1'b1, 3'd2, 32'h8000_0000, "R4 unmask all");
    wr(1'b0, 3'd0, 32'h8040_0040, "R3 load pending");
    wr(1'b0, 3'd1, 32'h8000_0000, "R9 open soft 15");
    chk("R9 soft 15 wins", {28'd0, irq_level}, 32'd15);
    wr(1'b0, 3'd2, 32'h8000_0000, "R5 close soft 15");
    chk("R5 back to 6", {28'd0, irq_level}, 32'd6);
    wr(1'b1, 3'd1, 32'h0000_0000, "R12 write read-only mask");
    rd(1'b1, 3'd1, "R12 mask unchanged");
    wr(1'b0, 3'd5, 32'hffff_ffff, "R12 unmapped write");
    rd(1'b0, 3'd1, "R12 clear reads zero");
    rd(1'b1, 3'd7, "R12 unmapped reads zero");
    wr(1'b1, 3'd4, 32'hffff_ffff, "R11 target write");
    rd(1'b1, 3'd4, "R11 target readback");
    dev_irq = 16'h0400;
    wr(1'b0, 3'd0, 32'h0, "R3 load with arrival");
    rd(1'b0, 3'd0, "R3 arrival kept");
    chk("R3 pend value", bus_rdata, 32'h0000_0400);

    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      dev_irq = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      case (op)
        0: wr(1'b0, 3'd1, $urandom(), "rand R4 cpu clr");
        1: wr(1'b0, 3'd2, $urandom() & $urandom() & $urandom(), "rand R5 cpu set");
        2: wr(1'b1, 3'd2, $urandom(), "rand R4 mst clr");
        3: wr(1'b1, 3'd3, $urandom() & $urandom() & $urandom(), "rand R5 mst set");
        4: wr(1'b0, 3'd0, $urandom() & $urandom(), "rand R3 pend load");
        5: wr($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), $urandom(), "rand R12 any write");
        6, 7: rd($urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)), "rand R7 read");
        default: step("rand R2 idle");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule